// File: doc/BRIEF.md
# Infrared Line Codec

This block sits between a UART and an infrared transceiver. On the transmit side it takes the serial bit the UART puts out and turns each bit period into an infrared line code. On the receive side it turns the raw detector signal back into a plain serial bit for the UART's receiver. A runtime select picks one of two line codes. In short-pulse code, a zero bit produces one brief flash at the start of its period. In carrier code, a zero bit produces a gated square wave near 500 kHz for the whole period. In both codes a one bit produces no emission. The start bit of every word is a zero, so it is coded like any other zero.

Timing comes from a 16x baud tick. Sixteen ticks make one bit period, and the UART bit is captured at the tick that closes a period. The carrier is made by dividing the system clock. A second runtime select routes the coded line either to the ordinary serial pin pair or to a dedicated infrared pin pair. The pin that is not selected is held at its inactive level, and the receive pin that is not selected is ignored. The short-pulse code is meant for rates up to 115.2 kbit/s and the carrier code for rates up to 19.2 kbaud.

Top module: `ir_line_codec`

## Requirements
- R1: After reset, with route select low, `std_txd_pin` and `ir_tx_pin` are 0 and `uart_rxd_out` is 1.
- R2: The encoder captures `uart_txd` at every 16th `baud_tick` after reset and codes that value over the next 16 ticks. A frame's start bit (value 0) is coded as a zero.
- R3: With `mode_sel` = 0 (short-pulse code), a captured 0 drives the selected transmit pin high for exactly 3 baud ticks, starting at the beginning of the period. A captured 1 keeps it low.
- R4: With `mode_sel` = 1 (carrier code), a captured 0 gates a square wave onto the selected transmit pin for the whole period. Each high half lasts CLK_HZ/(2*CARRIER_HZ) clocks, so half of every period is high. A captured 1 keeps the pin low.
- R5: With `route_ir` = 0, the coded line appears on `std_txd_pin` and `ir_tx_pin` stays 0. With `route_ir` = 1, it appears on `ir_tx_pin` and `std_txd_pin` stays 1.
- R6: `route_ir` selects the receive source: `std_rxd_pin` when 0, `ir_rxd_pin` when 1. Activity on the other pin has no effect on `uart_rxd_out`.
- R7: In short-pulse code, a rising edge on the selected receive pin drives `uart_rxd_out` to 0 within 3 clocks and holds it at 0 for 16 baud ticks. A new rising edge restarts the 16 ticks.
- R8: In carrier code, `uart_rxd_out` goes to 0 only after at least two edges on the receive pin, each within GAP_HALVES carrier half periods of the one before. A single edge leaves it at 1. It returns to 1 once that gap passes with no edge.
- R9: When the transmit pins are looped back to the receive pins, each transmitted bit comes back on `uart_rxd_out` one bit period later, in both codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-clock strobe at 16 times the bit rate |
| mode_sel | input | 1 | Line code: 0 short-pulse, 1 carrier |
| route_ir | input | 1 | Pin set: 0 standard serial pins, 1 dedicated IR pins |
| uart_txd | input | 1 | Serial transmit bit from the UART |
| uart_rxd_out | output | 1 | Recovered serial bit for the UART |
| std_txd_pin | output | 1 | Standard serial transmit pin |
| std_rxd_pin | input | 1 | Standard serial receive pin |
| ir_tx_pin | output | 1 | Dedicated IR emitter drive |
| ir_rxd_pin | input | 1 | Dedicated IR detector input |

## Verification
Some internal faults show up at once. If the sub-tick phase drifts or the captured bit is stale, the pulse lands in the wrong period, and the loopback data comparison fails at the middle of the next bit. If the pulse window or the carrier divider is wrong, the total high time measured over a frame changes, and so does the longest high run. A decoder whose hold counter or edge counter misbehaves shows a wrong `uart_rxd_out` within one bit period. A routing mistake shows at once as activity on the pin that should be quiet, or as garbage on the ignored receive pin reaching the output.

// File: rtl/ir_codec_pkg.sv
package ir_codec_pkg;
   typedef enum logic {
      LC_PULSE   = 1'b0,
      LC_CARRIER = 1'b1
   } line_code_e;
endpackage

// File: rtl/ir_carrier_gen.sv
// Free-running square wave: toggles every DIV system clocks.
module ir_carrier_gen #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic carrier
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("ir_carrier_gen: DIV must be at least 2");
   end

   logic [CW-1:0] div_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         carrier <= 1'b0;
      end else if (div_cnt == DIV_LAST) begin
         div_cnt <= '0;
         carrier <= ~carrier;
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ir_tx_encoder.sv
// Captures the UART bit at each period boundary and shapes it into a line code.
module ir_tx_encoder
   import ir_codec_pkg::*;
#(
   parameter int SUB         = 16,
   parameter int PULSE_TICKS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  line_code_e code,
   input  logic       txd,
   input  logic       carrier,
   output logic       tx_line
);
   localparam int PW = $clog2(SUB);
   localparam logic [PW-1:0] PH_LAST   = PW'(SUB - 1);
   localparam logic [PW-1:0] PULSE_END = PW'(PULSE_TICKS);

   if ((SUB < 4) || ((SUB & (SUB - 1)) != 0)) begin : g_bad_sub
      $error("ir_tx_encoder: SUB must be a power of two, at least 4");
   end
   if ((PULSE_TICKS < 1) || (PULSE_TICKS >= SUB)) begin : g_bad_pulse
      $error("ir_tx_encoder: PULSE_TICKS must lie in 1..SUB-1");
   end

   logic [PW-1:0] phase;
   logic          bit_q;
   logic          pulse_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         bit_q <= 1'b1;
      end else if (baud_tick) begin
         if (phase == PH_LAST) begin
            phase <= '0;
            bit_q <= txd;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

   assign pulse_win = (phase < PULSE_END);

   always_comb begin
      unique case (code)
         LC_PULSE:   tx_line = ~bit_q & pulse_win;
         LC_CARRIER: tx_line = ~bit_q & carrier;
         default:    tx_line = 1'b0;
      endcase
   end
endmodule

// File: rtl/ir_rx_decoder.sv
// Synchronises the detector input and recovers the serial bit.
module ir_rx_decoder
   import ir_codec_pkg::*;
#(
   parameter int SUB      = 16,
   parameter int SYNC     = 2,
   parameter int GAP_CLKS = 24
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  line_code_e code,
   input  logic       rx_raw,
   output logic       rxd
);
   localparam int HW = $clog2(SUB + 1);
   localparam int GW = $clog2(GAP_CLKS + 1);
   localparam logic [HW-1:0] HOLD_INIT = HW'(SUB);
   localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CLKS - 1);

   if (SYNC < 2) begin : g_bad_sync
      $error("ir_rx_decoder: SYNC must be at least 2");
   end
   if (GAP_CLKS < 2) begin : g_bad_gap
      $error("ir_rx_decoder: GAP_CLKS must be at least 2");
   end

   logic [SYNC-1:0] sync_q;
   logic            prev_q;
   logic            rx_s;
   logic            any_edge;
   logic            rise;

   for (genvar i = 0; i < SYNC; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[i] <= 1'b0;
         else        sync_q[i] <= (i == 0) ? rx_raw : sync_q[(i == 0) ? 0 : i - 1];
      end
   end

   assign rx_s     = sync_q[SYNC-1];
   assign any_edge = rx_s ^ prev_q;
   assign rise     = rx_s & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= rx_s;
   end

   // Short-pulse code: a flash opens a zero lasting one bit period.
   logic [HW-1:0] hold;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= '0;
      end else if (code != LC_PULSE) begin
         hold <= '0;
      end else if (rise) begin
         hold <= HOLD_INIT;
      end else if (baud_tick && (hold != '0)) begin
         hold <= hold - 1'b1;
      end
   end

   // Carrier code: two closely spaced edges mean carrier present.
   logic [1:0]    edge_cnt;
   logic [GW-1:0] gap_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
         gap_cnt  <= '0;
      end else if (code != LC_CARRIER) begin
         edge_cnt <= '0;
         gap_cnt  <= '0;
      end else if (any_edge) begin
         gap_cnt  <= '0;
         edge_cnt <= (edge_cnt == 2'd2) ? 2'd2 : edge_cnt + 2'd1;
      end else if (edge_cnt != '0) begin
         if (gap_cnt == GAP_LAST) begin
            gap_cnt  <= '0;
            edge_cnt <= '0;
         end else begin
            gap_cnt <= gap_cnt + 1'b1;
         end
      end
   end

   assign rxd = (code == LC_PULSE) ? (hold == '0) : (edge_cnt != 2'd2);
endmodule

// File: rtl/ir_pin_router.sv
// Steers the coded line to one pin pair and picks the matching receive source.
module ir_pin_router (
   input  logic route_ir,
   input  logic tx_line,
   input  logic std_rxd_pin,
   input  logic ir_rxd_pin,
   output logic std_txd_pin,
   output logic ir_tx_pin,
   output logic rx_sel
);
   always_comb begin
      if (route_ir) begin
         std_txd_pin = 1'b1;
         ir_tx_pin   = tx_line;
         rx_sel      = ir_rxd_pin;
      end else begin
         std_txd_pin = tx_line;
         ir_tx_pin   = 1'b0;
         rx_sel      = std_rxd_pin;
      end
   end
endmodule

// File: rtl/ir_line_codec.sv
module ir_line_codec
   import ir_codec_pkg::*;
#(
   parameter int CLK_HZ      = 8_000_000,
   parameter int CARRIER_HZ  = 500_000,
   parameter int SUBTICKS    = 16,
   parameter int PULSE_TICKS = 3,
   parameter int SYNC_STAGES = 2,
   parameter int GAP_HALVES  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic baud_tick,
   input  logic mode_sel,
   input  logic route_ir,
   input  logic uart_txd,
   output logic uart_rxd_out,
   output logic std_txd_pin,
   input  logic std_rxd_pin,
   output logic ir_tx_pin,
   input  logic ir_rxd_pin
);
   localparam int CARRIER_DIV = CLK_HZ / (2 * CARRIER_HZ);
   localparam int GAP_CLKS    = GAP_HALVES * CARRIER_DIV;

   if ((CLK_HZ % (2 * CARRIER_HZ)) != 0) begin : g_bad_clk
      $error("ir_line_codec: CLK_HZ must be a multiple of 2*CARRIER_HZ");
   end
   if (GAP_HALVES < 2) begin : g_bad_gap
      $error("ir_line_codec: GAP_HALVES must be at least 2");
   end

   line_code_e code;
   logic       carrier;
   logic       tx_line;
   logic       rx_sel;

   assign code = line_code_e'(mode_sel);

   ir_carrier_gen #(.DIV(CARRIER_DIV)) u_carrier (
      .clk     (clk),
      .rst_n   (rst_n),
      .carrier (carrier)
   );

   ir_tx_encoder #(.SUB(SUBTICKS), .PULSE_TICKS(PULSE_TICKS)) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .code      (code),
      .txd       (uart_txd),
      .carrier   (carrier),
      .tx_line   (tx_line)
   );

   ir_pin_router u_route (
      .route_ir    (route_ir),
      .tx_line     (tx_line),
      .std_rxd_pin (std_rxd_pin),
      .ir_rxd_pin  (ir_rxd_pin),
      .std_txd_pin (std_txd_pin),
      .ir_tx_pin   (ir_tx_pin),
      .rx_sel      (rx_sel)
   );

   ir_rx_decoder #(.SUB(SUBTICKS), .SYNC(SYNC_STAGES), .GAP_CLKS(GAP_CLKS)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .code      (code),
      .rx_raw    (rx_sel),
      .rxd       (uart_rxd_out)
   );
endmodule

// File: rtl/ir_line_codec_chk.sv
module ir_line_codec_chk #(
   parameter int PULSE = 3,
   parameter int DIV   = 8
) (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic mode_sel,
   input logic route_ir,
   input logic std_txd_pin,
   input logic ir_tx_pin
);
   logic        line;
   logic [7:0]  hi_ticks;
   logic [15:0] hi_clks;

   assign line = route_ir ? ir_tx_pin : std_txd_pin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_ticks <= '0;
         hi_clks  <= '0;
      end else if (!line) begin
         hi_ticks <= '0;
         hi_clks  <= '0;
      end else begin
         if (baud_tick && (hi_ticks != 8'hFF)) hi_ticks <= hi_ticks + 8'd1;
         if (hi_clks != 16'hFFFF)              hi_clks  <= hi_clks + 16'd1;
      end
   end

   // R5: dedicated emitter quiet while the standard pins are chosen
   p_ir_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !route_ir |-> !ir_tx_pin);

   // R5: standard transmit pin rests at mark while the IR pins are chosen
   p_std_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      route_ir |-> std_txd_pin);

   // R3: a flash never outlasts its tick window
   p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_sel |-> (hi_ticks <= 8'(PULSE)));

   // R4: a carrier high half never outlasts the divider
   p_half_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel |-> (hi_clks <= 16'(DIV)));
endmodule

bind ir_line_codec ir_line_codec_chk #(.PULSE(PULSE_TICKS), .DIV(CARRIER_DIV)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .baud_tick   (baud_tick),
   .mode_sel    (mode_sel),
   .route_ir    (route_ir),
   .std_txd_pin (std_txd_pin),
   .ir_tx_pin   (ir_tx_pin)
);

// File: tb/ir_line_codec_test.sv
module ir_line_codec_test;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_CLKS  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic mode_sel = 1'b0;
   logic route_ir = 1'b0;
   logic uart_txd = 1'b1;
   logic uart_rxd_out;
   logic std_txd_pin, ir_tx_pin;
   logic std_rxd_pin, ir_rxd_pin;
   logic ext_std = 1'b0, ext_ir = 1'b0;
   logic loop_std = 1'b0, loop_ir = 1'b0;
   logic garb_en = 1'b0;

   int checks = 0;
   int errors = 0;

   logic  exp_q[$];
   string tag_q[$];
   event  sample_ev;

   logic meas_en = 1'b0;
   int   hi_cnt, rise_cnt, run_cnt, max_run, quiet_viol;
   logic prev_line;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign std_rxd_pin = loop_std ? std_txd_pin : ext_std;
   assign ir_rxd_pin  = loop_ir  ? ir_tx_pin  : ext_ir;

   ir_line_codec uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .baud_tick    (baud_tick),
      .mode_sel     (mode_sel),
      .route_ir     (route_ir),
      .uart_txd     (uart_txd),
      .uart_rxd_out (uart_rxd_out),
      .std_txd_pin  (std_txd_pin),
      .std_rxd_pin  (std_rxd_pin),
      .ir_tx_pin    (ir_tx_pin),
      .ir_rxd_pin   (ir_rxd_pin)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Garbage on both external receive sources; only unlooped ones matter.
   initial begin
      forever begin
         repeat (5) @(negedge clk);
         if (garb_en) begin
            ext_std = ~ext_std;
            ext_ir  = ~ext_ir;
         end
      end
   end

   // Line measurement at negedges.
   always @(negedge clk) begin
      if (meas_en) begin
         logic ln;
         ln = route_ir ? ir_tx_pin : std_txd_pin;
         if (ln) begin
            hi_cnt++;
            run_cnt++;
            if (run_cnt > max_run) max_run = run_cnt;
         end else begin
            run_cnt = 0;
         end
         if (ln && !prev_line) rise_cnt++;
         prev_line = ln;
         if (route_ir ? !std_txd_pin : ir_tx_pin) quiet_viol++;
      end
   end

   task automatic meas_start();
      hi_cnt = 0; rise_cnt = 0; run_cnt = 0; max_run = 0; quiet_viol = 0;
      prev_line = 1'b0;
      meas_en = 1'b1;
   endtask

   task automatic one_tick();
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
      repeat (TICK_CLKS - 2) @(negedge clk);
   endtask

   // Driver: presents one UART bit for 16 ticks and queues its expected echo.
   task automatic send_bit(input logic b, input string req);
      uart_txd = b;
      for (int j = 0; j < 16; j++) begin
         one_tick();
         if (j == 7) -> sample_ev;
      end
      exp_q.push_back(b);
      tag_q.push_back(req);
   endtask

   // Monitor: mid-way through the next bit, the echo must match.
   initial begin
      forever begin
         @(sample_ev);
         if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(uart_rxd_out), int'(e));
         end
      end
   end

   task automatic flush();
      send_bit(1'b1, "flush");
      send_bit(1'b1, "flush");
      exp_q.delete();
      tag_q.delete();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset levels
      check("R1 std_txd", int'(std_txd_pin), 0);
      check("R1 ir_tx", int'(ir_tx_pin), 0);
      check("R1 rxd", int'(uart_rxd_out), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // Short-pulse code on standard pins, garbage on the IR detector (R6).
      mode_sel = 1'b0; route_ir = 1'b0; loop_std = 1'b1; loop_ir = 1'b0;
      flush();
      garb_en = 1'b1;
      meas_start();
      send_bit(1'b0, "R2 start bit pulse");
      send_bit(1'b1, "R9 pulse loop");
      send_bit(1'b0, "R7 pulse loop");
      send_bit(1'b1, "R6 ignored ir pin");
      send_bit(1'b1, "R9 pulse loop");
      send_bit(1'b0, "R7 pulse loop");
      send_bit(1'b0, "R7 back-to-back zeros");
      send_bit(1'b1, "R9 pulse loop");
      send_bit(1'b1, "R9 pulse loop");
      send_bit(1'b1, "R9 pulse loop");
      meas_en = 1'b0;
      check("R3 total high clocks", hi_cnt, 4 * 3 * TICK_CLKS);
      check("R3 flashes per zero", rise_cnt, 4);
      check("R3 flash length", max_run, 3 * TICK_CLKS);
      check("R5 ir pin quiet", quiet_viol, 0);
      garb_en = 1'b0;
      ext_std = 1'b0; ext_ir = 1'b0;

      // Carrier code on IR pins, garbage on the standard receive pin (R6).
      mode_sel = 1'b1; route_ir = 1'b1; loop_std = 1'b0; loop_ir = 1'b1;
      flush();
      garb_en = 1'b1;
      meas_start();
      send_bit(1'b0, "R2 start bit carrier");
      send_bit(1'b0, "R8 carrier loop");
      send_bit(1'b1, "R6 ignored std pin");
      send_bit(1'b0, "R8 carrier loop");
      send_bit(1'b1, "R9 carrier loop");
      send_bit(1'b1, "R9 carrier loop");
      send_bit(1'b1, "R9 carrier loop");
      meas_en = 1'b0;
      check("R4 total high clocks", hi_cnt, 3 * 8 * TICK_CLKS);
      check("R4 half period", max_run, 8);
      check("R5 std pin at mark", quiet_viol, 0);
      garb_en = 1'b0;
      ext_std = 1'b0; ext_ir = 1'b0;

      // R8: one lone edge is not carrier.
      loop_ir = 1'b0;
      flush();
      @(negedge clk) ext_ir = 1'b1;
      repeat (16) one_tick();
      check("R8 single edge", int'(uart_rxd_out), 1);
      ext_ir = 1'b0;
      repeat (16) one_tick();

      // R7: lone flash timing in short-pulse code.
      mode_sel = 1'b0;
      repeat (16) one_tick();
      @(negedge clk) ext_ir = 1'b1;
      repeat (3) @(negedge clk);
      ext_ir = 1'b0;
      check("R7 flash seen", int'(uart_rxd_out), 0);
      repeat (15) one_tick();
      check("R7 hold 15 ticks", int'(uart_rxd_out), 0);
      one_tick();
      check("R7 release at 16", int'(uart_rxd_out), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule